// File: doc/BRIEF.md
# Memory-Mapped Single-Transfer Master Sequencer

This block is a bus master for a memory-mapped slave port with a waitrequest-style stall. A client hands it one transaction at a time through a valid/ready command port: a direction bit, an address, a byte-enable mask and, for writes, a data word. The sequencer drives the transfer onto the bus and keeps every bus signal steady for as long as the slave stalls. On completion it returns to idle values on the bus. For reads it then presents the captured word on a result port for one cycle.

Only one transfer is in flight at any time. After reset the bus stays quiet for a programmable number of cycles before the first command is taken. After each transfer there is one release cycle with all bus outputs at zero. A stall watchdog abandons a transfer whose slave never lets go, and reports this with a one-cycle timeout pulse.

Top module: `mm_txn_master`

## Requirements
- R1: On the cycle after a read command is accepted (cmd_valid and cmd_ready high at a clock edge, cmd_write=0), bus_rd is 1, bus_wr is 0, bus_addr and bus_be equal the command's values and bus_wdata is 0.
- R2: On the cycle after a write command is accepted (cmd_write=1), bus_wr is 1, bus_rd is 0, and bus_addr, bus_be and bus_wdata equal the command's values.
- R3: While bus_waitreq is sampled high during a transfer, and the watchdog does not expire, bus_addr, bus_be, bus_wdata, bus_rd and bus_wr keep their values into the next cycle.
- R4: A transfer completes at the first clock edge where bus_waitreq is low. For a read, bus_rdata is sampled at that edge and shown on rsp_rdata, with rsp_valid high for exactly the following cycle. A completed write gives no rsp_valid.
- R5: In the cycle after a transfer completes or is abandoned, bus_rd and bus_wr are 0, bus_addr, bus_be and bus_wdata are 0, and cmd_ready is 0. cmd_ready is 1 in the cycle after that.
- R6: After reset is released, cmd_ready, bus_rd and bus_wr stay 0 for the first STARTUP_CYC clock edges. cmd_ready is 1 once STARTUP_CYC edges have passed.
- R7: cmd_ready is high only when no transfer is active. A command offered while cmd_ready is low is not taken, and the bus stays idle.
- R8: A slave may stall for up to TIMEOUT_CYC wait cycles and the transfer still completes normally. If bus_waitreq is sampled high on TIMEOUT_CYC+1 consecutive edges of one transfer, the transfer is abandoned at that edge. rsp_timeout is then high for exactly the next cycle, rsp_valid stays low, and the bus is released as in R5.
- R9: bus_rd and bus_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_be | input | DATA_W/8 | Byte-enable mask |
| cmd_wdata | input | DATA_W | Write data |
| bus_addr | output | ADDR_W | Bus address |
| bus_be | output | DATA_W/8 | Bus byte enables |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | DATA_W | Bus write data |
| bus_waitreq | input | 1 | Slave stall request |
| bus_rdata | input | DATA_W | Slave read data |
| rsp_valid | output | 1 | One-cycle pulse, read result present |
| rsp_rdata | output | DATA_W | Captured read word |
| rsp_timeout | output | 1 | One-cycle pulse, transfer abandoned by watchdog |

## Verification
On every cycle, the assertions check that the bus stays frozen under a stall, that a completed transfer drops its strobe, that the two strobes never overlap, and that the result and timeout signals are single pulses. They also check that cmd_ready implies an idle bus and that the startup hold and the watchdog count stay in bounds. Other behaviour can only be shown by the bench's scenarios: that the right command fields reach the bus, that the read word is taken on the exact releasing edge and not during a stall, that a stall of exactly TIMEOUT_CYC cycles still completes while one cycle more aborts, and that the sequencer recovers after an abort.

// File: rtl/mmtx_pkg.sv
package mmtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RELEASE = 2'd2
  } mmtx_state_e;

  // Number of bits needed to count from 0 up to and including n.
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Next state of the transfer sequence.
  function automatic mmtx_state_e next_state(input mmtx_state_e cur,
                                             input logic accept,
                                             input logic finish,
                                             input logic abort);
    mmtx_state_e nxt;
    nxt = cur;
    case (cur)
      ST_IDLE:    if (accept) nxt = ST_ACCESS;
      ST_ACCESS:  if (finish || abort) nxt = ST_RELEASE;
      ST_RELEASE: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/mmtx_startup.sv
module mmtx_startup #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  output logic done_o
);
  localparam int CW = mmtx_pkg::cnt_bits(HOLD);

  logic [CW-1:0] hold_cnt;

  assign done_o = (hold_cnt == CW'(HOLD));

  always_ff @(posedge clk) begin
    if (rst)          hold_cnt <= '0;
    else if (!done_o) hold_cnt <= hold_cnt + 1'b1;
  end

  assert_hold_bound_R6: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= CW'(HOLD));

endmodule

// File: rtl/mmtx_watchdog.sv
module mmtx_watchdog #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic stall_i,
  output logic expire_o
);
  localparam int CW = mmtx_pkg::cnt_bits(LIMIT);

  logic [CW-1:0] stall_cnt;
  logic          stall_seen;

  assign stall_seen = active_i && stall_i;
  assign expire_o   = stall_seen && (stall_cnt == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || !stall_seen || expire_o) stall_cnt <= '0;
    else                                stall_cnt <= stall_cnt + 1'b1;
  end

  assert_wd_bound_R8: assert property (@(posedge clk) disable iff (rst)
    stall_cnt <= CW'(LIMIT));

  assert_wd_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> stall_cnt == '0);

endmodule

// File: rtl/mmtx_ctrl.sv
module mmtx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_ok_i,
  input  logic cmd_valid_i,
  input  logic waitreq_i,
  input  logic expire_i,
  output logic cmd_ready_o,
  output logic accept_o,
  output logic finish_o,
  output logic abort_o,
  output logic access_o
);
  import mmtx_pkg::*;

  mmtx_state_e state;

  assign access_o    = (state == ST_ACCESS);
  assign cmd_ready_o = (state == ST_IDLE) && start_ok_i;
  assign accept_o    = cmd_ready_o && cmd_valid_i;
  assign finish_o    = access_o && !waitreq_i;
  assign abort_o     = access_o && expire_i;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= next_state(state, accept_o, finish_o, abort_o);
  end

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !cmd_ready_o);

  assert_release_then_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (finish_o || abort_o) |=> !cmd_ready_o);

  assert_end_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(finish_o && abort_o));

endmodule

// File: rtl/mm_txn_master.sv
module mm_txn_master #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int STARTUP_CYC = 4,
  parameter int TIMEOUT_CYC = 8,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BE_W-1:0]   cmd_be,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_waitreq,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout
);

  // Named internal events, shared by logic and assertions.
  logic start_done;
  logic accept;
  logic finish;
  logic abort;
  logic access;
  logic expire;

  mmtx_startup #(.HOLD(STARTUP_CYC)) u_startup (
    .clk    (clk),
    .rst    (rst),
    .done_o (start_done)
  );

  mmtx_watchdog #(.LIMIT(TIMEOUT_CYC)) u_watchdog (
    .clk      (clk),
    .rst      (rst),
    .active_i (access),
    .stall_i  (bus_waitreq),
    .expire_o (expire)
  );

  mmtx_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_ok_i  (start_done),
    .cmd_valid_i (cmd_valid),
    .waitreq_i   (bus_waitreq),
    .expire_i    (expire),
    .cmd_ready_o (cmd_ready),
    .accept_o    (accept),
    .finish_o    (finish),
    .abort_o     (abort),
    .access_o    (access)
  );

  // Bus drive registers: loaded on accept, cleared on completion or abort.
  always_ff @(posedge clk) begin
    if (rst || finish || abort) begin
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
    end else if (accept) begin
      bus_addr  <= cmd_addr;
      bus_be    <= cmd_be;
      bus_wdata <= cmd_write ? cmd_wdata : '0;
      bus_rd    <= !cmd_write;
      bus_wr    <= cmd_write;
    end
  end

  // Result registers: one-cycle pulses after the ending edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      rsp_valid   <= finish && bus_rd;
      rsp_timeout <= abort;
      if (finish && bus_rd) rsp_rdata <= bus_rdata;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && bus_waitreq && !expire)
      |=> $stable({bus_addr, bus_be, bus_wdata, bus_rd, bus_wr}));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && (!bus_waitreq || expire))
      |=> (!bus_rd && !bus_wr && bus_addr == '0 && bus_be == '0 && bus_wdata == '0));

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_tmo_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |=> !rsp_timeout);

  assert_tmo_no_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    !(rsp_timeout && rsp_valid));

  assert_startup_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !start_done |-> (!cmd_ready && !bus_rd && !bus_wr));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!bus_rd && !bus_wr));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

endmodule

// File: tb/mm_txn_master_test.sv
module mm_txn_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W = DATA_W / 8;
  localparam int STARTUP_CYC = 4;
  localparam int TIMEOUT_CYC = 8;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [BE_W-1:0] cmd_be = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic [ADDR_W-1:0] bus_addr;
  logic [BE_W-1:0] bus_be;
  logic bus_rd, bus_wr;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_waitreq = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic rsp_valid, rsp_timeout;
  logic [DATA_W-1:0] rsp_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_txn_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .STARTUP_CYC(STARTUP_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) uut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout)
  );

  // Slave content model: the word a slave returns for an address.
  function automatic logic [DATA_W-1:0] slave_word(input logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  // Expected bus image {rd, wr, be, addr} for a command.
  function automatic logic [63:0] bus_image(input bit w, input logic [BE_W-1:0] be,
                                            input logic [ADDR_W-1:0] a);
    return {26'd0, !w, w, be, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] bus_now();
    return {26'd0, bus_rd, bus_wr, bus_be, bus_addr};
  endfunction

  // One transfer; waits = number of stall cycles the slave inserts.
  task automatic run_txn(input bit w, input logic [ADDR_W-1:0] a,
                         input logic [BE_W-1:0] be, input logic [DATA_W-1:0] wd,
                         input int waits);
    bit abort_exp;
    int last;
    logic [DATA_W-1:0] rword;
    abort_exp = (waits > TIMEOUT_CYC);
    last = abort_exp ? TIMEOUT_CYC : waits;
    rword = slave_word(a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_be = be; cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = $urandom; cmd_wdata = $urandom;
    for (int i = 0; i <= last; i++) begin
      if (i == 0)
        chk(bus_now() == bus_image(w, be, a), w ? "R2 drive" : "R1 drive",
            bus_now(), bus_image(w, be, a));
      else
        chk(bus_now() == bus_image(w, be, a), "R3 hold", bus_now(), bus_image(w, be, a));
      chk(bus_wdata == (w ? wd : '0), w ? "R2 wdata" : "R1 wdata zero",
          64'(bus_wdata), 64'(w ? wd : '0));
      chk(!(bus_rd && bus_wr), "R9 exclusive", 64'({bus_rd, bus_wr}), 64'(0));
      chk(!cmd_ready, "R7 busy", 64'(cmd_ready), 64'(0));
      if (i < waits) begin
        bus_waitreq = 1'b1;
        bus_rdata = $urandom;
      end else begin
        bus_waitreq = 1'b0;
        bus_rdata = w ? $urandom : rword;
      end
      @(posedge clk);
      @(negedge clk);
    end
    bus_waitreq = 1'b0;
    bus_rdata = $urandom;
    chk({bus_rd, bus_wr} == 2'b00 && bus_addr == '0 && bus_be == '0 && bus_wdata == '0,
        "R5 release", bus_now() | 64'(bus_wdata), 64'(0));
    chk(!cmd_ready, "R5 not ready in release", 64'(cmd_ready), 64'(0));
    chk(rsp_valid == (!w && !abort_exp), "R4 rsp_valid", 64'(rsp_valid),
        64'(!w && !abort_exp));
    if (!w && !abort_exp)
      chk(rsp_rdata == rword, "R4 rsp_rdata", 64'(rsp_rdata), 64'(rword));
    chk(rsp_timeout == abort_exp, "R8 timeout", 64'(rsp_timeout), 64'(abort_exp));
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid && !rsp_timeout, "R4 single pulse", 64'({rsp_valid, rsp_timeout}), 64'(0));
    chk(cmd_ready, "R5 ready after release", 64'(cmd_ready), 64'(1));
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!cmd_ready && !bus_rd && !bus_wr && !rsp_valid && !rsp_timeout,
        "R6 reset state", bus_now(), 64'(0));
    // R7: a command offered during startup is not taken.
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 32'h44; cmd_be = 4'hF;
    rst = 1'b0;
    for (int k = 1; k <= STARTUP_CYC; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cmd_ready == (k >= STARTUP_CYC), "R6 startup hold", 64'(cmd_ready),
          64'(k >= STARTUP_CYC));
      chk(!bus_rd && !bus_wr, "R7 ignored while not ready", bus_now(), 64'(0));
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr, "R7 no late take", bus_now(), 64'(0));

    // Directed corners.
    run_txn(1'b0, 32'h0000_0002, 4'b0001, '0, 0);
    run_txn(1'b1, 32'h0000_0010, 4'b0011, 32'hCAFE_F00D, 0);
    run_txn(1'b0, 32'h0000_0003, 4'b1111, '0, 3);
    run_txn(1'b0, 32'hDEAD_0000, 4'b1000, '0, TIMEOUT_CYC);
    run_txn(1'b1, 32'h1234_5678, 4'b0110, 32'h0BAD_BEEF, TIMEOUT_CYC);
    run_txn(1'b0, 32'hFFFF_FFFC, 4'b1111, '0, TIMEOUT_CYC + 1);
    run_txn(1'b1, 32'h0000_0020, 4'b1111, 32'h1111_2222, TIMEOUT_CYC + 5);
    run_txn(1'b0, 32'h0000_0030, 4'b0101, '0, 1);

    // Constrained random mix.
    for (int n = 0; n < 40; n++) begin
      run_txn(1'($urandom), $urandom, 4'($urandom_range(1, 15)), $urandom,
              ($urandom_range(0, 9) == 0) ? TIMEOUT_CYC + 1 : $urandom_range(0, TIMEOUT_CYC));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule